// File: doc/BRIEF.md
# Bipolar Line Code Decoder (AMI / B3ZS)

This block sits behind a receive clock-and-data recovery stage and turns its dual-rail ternary symbols back into binary data. Each symbol arrives on a positive and a negative rail, qualified by a valid strobe. The rails encode a zero as 00, a positive mark as 10 and a negative mark as 01. A mode input selects plain alternate-mark-inversion decoding or B3ZS decoding. In B3ZS decoding, the decoder finds the B0V and 00V patterns that stand in for runs of three zeros and turns them back into zeros.

The decoder tracks the polarity of the last mark and the parity of the alternating pulses seen since the last accepted substitution. From these it tells a legal substitution violation apart from a line error, and it flags each error on the symbol that caused it. Every symbol passes through a three-symbol window, so a violation pulse can still cancel the two symbols before it. A format input selects how results leave the block. In single-rail format they appear as one data bit plus a violation strobe. In dual-rail format the rails are forwarded with the substituted marks removed.

Top module: `lcd_decoder`

## Requirements
- R1: With rails 00 read as a zero and 10 or 01 read as a mark, single-rail format outputs data 1 for every mark and 0 for every zero that is not part of a substitution.
- R2: In AMI mode (mode_b3zs = 0), a mark with the same polarity as the previous mark is output as data 1 and raises out_viol on that symbol. AMI mode never removes a mark.
- R3: In B3ZS mode, a mark with the same polarity as the previous mark, preceded by two zeros, is a legal 00V when the parity rule of R5 holds. All three symbols are output as zeros with no flag.
- R4: In B3ZS mode, a same-polarity mark preceded by a zero and, before that, an unflagged alternating mark (B) is a legal B0V when the parity rule of R5 holds. All three symbols are output as zeros with no flag.
- R5: A same-polarity mark is a legal V only if the number of alternating marks since the last legal V (or since reset) is odd. A legal V clears that count. Any other same-polarity mark is output as data 1 with out_viol set, and it leaves the count unchanged.
- R6: Rails 11 are output as data 1 with out_viol set. They do not change the last-mark polarity or the pulse count, and they are not zero for substitution matching.
- R7: Each accepted symbol leaves the block in the cycle after the third later accepted symbol. out_valid is high exactly in the cycle after each in_valid cycle. After reset, three zero symbols with no flag come out first.
- R8: In dual-rail format (fmt_single = 0), out_pos/out_neg carry the symbol's rails (00 where a substitution was removed), and out_data and out_viol stay low.
- R9: In single-rail format (fmt_single = 1), out_pos and out_neg stay low.
- R10: Reset clears every output. It sets the last-mark polarity to positive and the pulse count to even, so a positive first mark is a violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Symbol on the rails is accepted this cycle |
| in_pos | input | 1 | Positive-mark rail |
| in_neg | input | 1 | Negative-mark rail |
| mode_b3zs | input | 1 | 1: B3ZS decoding, 0: AMI decoding |
| fmt_single | input | 1 | 1: single-rail output, 0: dual-rail output |
| out_valid | output | 1 | An output symbol is present |
| out_data | output | 1 | Decoded NRZ bit (single-rail format) |
| out_pos | output | 1 | Decoded positive rail (dual-rail format) |
| out_neg | output | 1 | Decoded negative rail (dual-rail format) |
| out_viol | output | 1 | Bipolar violation on this symbol (single-rail format) |

## Verification
The bench builds the decoder with its default three-symbol window, the shortest depth that still holds a whole B0V pattern. At this depth every substitution has its B in the oldest retained slot when the V arrives. So the case where a B must be cancelled just before it is released, and the case where the window is still filled with reset zeros, both come up within the first few symbols of a run. Random streams mix idle gaps, both modes and both formats. Injected illegal rails, wrong-polarity marks and substitutions with even parity put every branch of the violation decision within reach.

// File: rtl/lcd_pkg.sv
`timescale 1ns/1ps
package lcd_pkg;

    // Symbol class seen on the two receive rails.
    typedef enum logic [1:0] {
        SYM_ZERO  = 2'd0,
        SYM_PLUS  = 2'd1,
        SYM_MINUS = 2'd2,
        SYM_BAD   = 2'd3
    } sym_e;

    // One decoded symbol held in the decision window.
    typedef struct packed {
        logic pos;   // forwarded positive rail after decoding
        logic neg;   // forwarded negative rail after decoding
        logic data;  // NRZ bit
        logic viol;  // bipolar violation tied to this symbol
    } slot_t;

endpackage

// File: rtl/lcd_sym_class.sv
`timescale 1ns/1ps
module lcd_sym_class
    import lcd_pkg::*;
(
    input  logic rail_p,
    input  logic rail_n,
    output sym_e kind
);
    always_comb begin
        unique case ({rail_p, rail_n})
            2'b00:   kind = SYM_ZERO;
            2'b10:   kind = SYM_PLUS;
            2'b01:   kind = SYM_MINUS;
            default: kind = SYM_BAD;
        endcase
    end
endmodule

// File: rtl/lcd_v_judge.sv
`timescale 1ns/1ps
module lcd_v_judge
    import lcd_pkg::*;
(
    input  logic  mode_b3zs,
    input  sym_e  kind,
    input  logic  last_neg,    // polarity of the last alternating mark, 1 = negative
    input  logic  par,         // parity of alternating marks since last legal V
    input  logic  a0_pos,      // newest held symbol, rails
    input  logic  a0_neg,
    input  slot_t a1,          // symbol before that
    output slot_t new_slot,
    output logic  clr_b,
    output logic  v_legal,
    output logic  last_neg_nx,
    output logic  par_nx
);
    logic is_mark;
    logic x_neg;
    logic same_pol;
    logic a0_zero;
    logic a1_zero;
    logic a1_bmark;

    always_comb begin
        is_mark  = (kind == SYM_PLUS) || (kind == SYM_MINUS);
        x_neg    = (kind == SYM_MINUS);
        same_pol = is_mark && (x_neg == last_neg);
        a0_zero  = !a0_pos && !a0_neg;
        a1_zero  = !a1.pos && !a1.neg;
        a1_bmark = a1.data && !a1.viol && (a1.pos ^ a1.neg);

        v_legal  = mode_b3zs && same_pol && par && a0_zero && (a1_zero || a1_bmark);
        clr_b    = v_legal && a1_bmark;

        new_slot = '0;
        unique case (kind)
            SYM_BAD: begin
                new_slot.pos  = 1'b1;
                new_slot.neg  = 1'b1;
                new_slot.data = 1'b1;
                new_slot.viol = 1'b1;
            end
            SYM_PLUS, SYM_MINUS: begin
                if (!v_legal) begin
                    new_slot.pos  = !x_neg;
                    new_slot.neg  = x_neg;
                    new_slot.data = 1'b1;
                    new_slot.viol = same_pol;
                end
            end
            default: new_slot = '0;
        endcase

        last_neg_nx = (is_mark && !same_pol) ? x_neg : last_neg;
        if (v_legal) begin
            par_nx = 1'b0;
        end else if (is_mark && !same_pol) begin
            par_nx = ~par;
        end else begin
            par_nx = par;
        end
    end
endmodule

// File: rtl/lcd_out_sel.sv
`timescale 1ns/1ps
module lcd_out_sel
    import lcd_pkg::*;
(
    input  slot_t rel,
    input  logic  fmt_single,
    output logic  o_data,
    output logic  o_pos,
    output logic  o_neg,
    output logic  o_viol
);
    always_comb begin
        if (fmt_single) begin
            o_data = rel.data;
            o_viol = rel.viol;
            o_pos  = 1'b0;
            o_neg  = 1'b0;
        end else begin
            o_data = 1'b0;
            o_viol = 1'b0;
            o_pos  = rel.pos;
            o_neg  = rel.neg;
        end
    end
endmodule

// File: rtl/lcd_decoder.sv
`timescale 1ns/1ps
module lcd_decoder
    import lcd_pkg::*;
#(
    parameter int LAT = 3   // symbols held before release; at least 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_pos,
    input  logic in_neg,
    input  logic mode_b3zs,
    input  logic fmt_single,
    output logic out_valid,
    output logic out_data,
    output logic out_pos,
    output logic out_neg,
    output logic out_viol
);
    localparam int NEWEST = LAT - 1;
    localparam int B_SLOT = LAT - 3;   // where the older neighbour lands after a shift

    typedef struct packed {
        slot_t [LAT-1:0] win;
        logic            last_neg;
        logic            par;
        logic            ov;
        logic            od;
        logic            op;
        logic            on;
        logic            oviol;
    } st_t;

    st_t st_d, st_q;

    sym_e  kind;
    slot_t new_slot;
    logic  clr_b;
    logic  v_legal;
    logic  last_neg_nx;
    logic  par_nx;
    logic  sel_data, sel_pos, sel_neg, sel_viol;

    lcd_sym_class u_class (
        .rail_p (in_pos),
        .rail_n (in_neg),
        .kind   (kind)
    );

    lcd_v_judge u_judge (
        .mode_b3zs   (mode_b3zs),
        .kind        (kind),
        .last_neg    (st_q.last_neg),
        .par         (st_q.par),
        .a0_pos      (st_q.win[NEWEST].pos),
        .a0_neg      (st_q.win[NEWEST].neg),
        .a1          (st_q.win[NEWEST-1]),
        .new_slot    (new_slot),
        .clr_b       (clr_b),
        .v_legal     (v_legal),
        .last_neg_nx (last_neg_nx),
        .par_nx      (par_nx)
    );

    lcd_out_sel u_sel (
        .rel        (st_q.win[0]),
        .fmt_single (fmt_single),
        .o_data     (sel_data),
        .o_pos      (sel_pos),
        .o_neg      (sel_neg),
        .o_viol     (sel_viol)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ov    = in_valid;
        st_d.od    = 1'b0;
        st_d.op    = 1'b0;
        st_d.on    = 1'b0;
        st_d.oviol = 1'b0;
        if (in_valid) begin
            st_d.od    = sel_data;
            st_d.op    = sel_pos;
            st_d.on    = sel_neg;
            st_d.oviol = sel_viol;
            for (int i = 0; i < LAT - 1; i++) begin
                st_d.win[i] = st_q.win[i+1];
            end
            st_d.win[NEWEST] = new_slot;
            if (clr_b) begin
                st_d.win[B_SLOT] = '0;
            end
            st_d.last_neg = last_neg_nx;
            st_d.par      = par_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ov;
    assign out_data  = st_q.od;
    assign out_pos   = st_q.op;
    assign out_neg   = st_q.on;
    assign out_viol  = st_q.oviol;

    p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_viol && !out_data && !out_pos && !out_neg));

    p_dual_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !fmt_single) |=> (!out_viol && !out_data));

    p_single_rails_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt_single) |=> (!out_pos && !out_neg));

    p_bad_keeps_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_pos && in_neg) |=>
            ($stable(st_q.last_neg) && $stable(st_q.par) && st_q.win[NEWEST].viol));

    p_legal_v_clears_par_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && v_legal) |=> !st_q.par);

    p_ami_keeps_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode_b3zs && (in_pos ^ in_neg)) |=> st_q.win[NEWEST].data);

endmodule

// File: tb/lcd_decoder_bench.sv
`timescale 1ns/1ps
module lcd_decoder_bench;
    localparam int MAXN = 700;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, in_valid, in_pos, in_neg, mode_b3zs, fmt_single;
    logic out_valid, out_data, out_pos, out_neg, out_viol;

    lcd_decoder u_lcd_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pos(in_pos), .in_neg(in_neg),
        .mode_b3zs(mode_b3zs), .fmt_single(fmt_single), .out_valid(out_valid),
        .out_data(out_data), .out_pos(out_pos), .out_neg(out_neg), .out_viol(out_viol)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;
    logic sp [MAXN];
    logic sn [MAXN];
    logic ed [MAXN];
    logic ev [MAXN];
    logic ep [MAXN];
    logic en [MAXN];
    logic [3:0] obs [MAXN+8];
    int  oc;
    bit  prev_v;

    task automatic chk(bit ok, string tag, int idx, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s idx=%0d actual=%b expected=%b", tag, idx, act, exp);
        end
    endtask

    task automatic step(logic v, logic p, logic n, string tag);
        @(negedge clk);
        if (prev_v) chk(out_valid === 1'b1, {tag, " R7 valid timing"}, oc, {3'b0, out_valid}, 4'b0001);
        if (out_valid) begin
            if (oc < MAXN + 8) obs[oc] = {out_data, out_viol, out_pos, out_neg};
            oc++;
        end
        in_valid = v; in_pos = p; in_neg = n;
        prev_v = v;
    endtask

    task automatic do_reset(bit b3, bit fmt);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; in_pos = 1'b0; in_neg = 1'b0;
        mode_b3zs = b3; fmt_single = fmt;
        repeat (3) @(negedge clk);
        chk({out_valid, out_data, out_viol, out_pos, out_neg} == 5'b0, "R10 reset outputs", 0,
            {out_data, out_viol, out_pos, out_neg}, 4'b0);
        rst_n = 1'b1;
        oc = 0; prev_v = 0;
    endtask

    // Reference transmitter: random bits into AMI or B3ZS symbols; expected = source.
    task automatic encode(bit b3, int n);
        logic lneg = 1'b0;
        logic par  = 1'b0;
        int   zrun = 0;
        for (int i = 0; i < n; i++) begin
            logic b = logic'($urandom_range(0, 1));
            ed[i] = b; ev[i] = 1'b0;
            if (b) begin
                lneg = ~lneg; par = ~par; zrun = 0;
                sp[i] = !lneg; sn[i] = lneg;
            end else begin
                sp[i] = 1'b0; sn[i] = 1'b0;
                if (b3) begin
                    zrun++;
                    if (zrun == 3) begin
                        if (!par) begin
                            lneg = ~lneg;
                            sp[i-2] = !lneg; sn[i-2] = lneg;
                        end
                        sp[i] = !lneg; sn[i] = lneg;
                        par = 1'b0; zrun = 0;
                    end
                end
            end
        end
        for (int i = 0; i < n; i++) begin
            ep[i] = ed[i] ? sp[i] : 1'b0;
            en[i] = ed[i] ? sn[i] : 1'b0;
        end
    endtask

    task automatic inject(int n);
        for (int i = 0; i < n; i++) begin
            if ($urandom_range(0, 19) == 0) begin
                logic [1:0] r = 2'($urandom_range(0, 3));
                sp[i] = r[1]; sn[i] = r[0];
            end
        end
    endtask

    // Expected decode from the requirement rules R1..R6.
    task automatic model(bit b3, int n);
        logic lneg = 1'b0;
        logic par  = 1'b0;
        for (int i = 0; i < n; i++) begin
            bit a0z = (i < 1) ? 1'b1 : (!ep[i-1] && !en[i-1]);
            bit a1z = (i < 2) ? 1'b1 : (!ep[i-2] && !en[i-2]);
            bit a1b = (i < 2) ? 1'b0 : (ed[i-2] && !ev[i-2] && (ep[i-2] ^ en[i-2]));
            if (sp[i] && sn[i]) begin
                ed[i] = 1; ev[i] = 1; ep[i] = 1; en[i] = 1;
            end else if (!sp[i] && !sn[i]) begin
                ed[i] = 0; ev[i] = 0; ep[i] = 0; en[i] = 0;
            end else begin
                logic xn = sn[i];
                bit same = (xn == lneg);
                if (b3 && same && par && a0z && (a1z || a1b)) begin
                    ed[i] = 0; ev[i] = 0; ep[i] = 0; en[i] = 0;
                    if (a1b) begin ed[i-2] = 0; ep[i-2] = 0; en[i-2] = 0; end
                    par = 0;
                end else begin
                    ed[i] = 1; ev[i] = same; ep[i] = sp[i]; en[i] = sn[i];
                    if (!same) begin lneg = xn; par = ~par; end
                end
            end
        end
    endtask

    task automatic run_seq(bit b3, bit fmt, int n, int gap_pct, string tag);
        do_reset(b3, fmt);
        for (int i = 0; i < n + 3; i++) begin
            while (gap_pct > 0 && $urandom_range(0, 99) < gap_pct) step(0, 0, 0, tag);
            if (i < n) step(1, sp[i], sn[i], tag);
            else       step(1, 0, 0, tag);
        end
        repeat (3) step(0, 0, 0, tag);
        chk(oc == n + 3, {tag, " R7 symbol count"}, oc, 4'(oc), 4'(n + 3));
        for (int k = 0; k < n + 3 && k < oc; k++) begin
            logic [3:0] exp;
            if (k < 3)      exp = 4'b0;
            else if (fmt)   exp = {ed[k-3], ev[k-3], 2'b00};
            else            exp = {2'b00, ep[k-3], en[k-3]};
            chk(obs[k] == exp, tag, k, obs[k], exp);
        end
    endtask

    task automatic put(int i, logic p, logic n, logic d, logic v);
        sp[i] = p; sn[i] = n; ed[i] = d; ev[i] = v; ep[i] = d ? p : 1'b0; en[i] = d ? n : 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5eed_0b3a));
        rst_n = 0; in_valid = 0; in_pos = 0; in_neg = 0; mode_b3zs = 0; fmt_single = 1;

        // R2: AMI repeated positive mark flagged, kept as 1
        put(0, 0, 1, 1, 0); put(1, 1, 0, 1, 0); put(2, 1, 0, 1, 1); put(3, 0, 0, 0, 0);
        run_seq(0, 1, 4, 0, "R2 ami violation");
        // R2: zeros then same polarity in AMI are not removed
        put(0, 0, 1, 1, 0); put(1, 0, 0, 0, 0); put(2, 0, 0, 0, 0); put(3, 0, 1, 1, 1);
        run_seq(0, 1, 4, 0, "R2 ami no substitution");
        // R6: rails 11 flagged, state untouched
        put(0, 0, 1, 1, 0); put(1, 1, 1, 1, 1); put(2, 1, 0, 1, 0); put(3, 0, 0, 0, 0);
        ep[1] = 1; en[1] = 1;
        run_seq(0, 1, 4, 0, "R6 illegal rails");
        // R10: positive first mark violates reset polarity
        put(0, 1, 0, 1, 1); put(1, 0, 0, 0, 0);
        run_seq(0, 1, 2, 0, "R10 reset polarity");
        // R3: legal 00V
        put(0, 0, 1, 1, 0); put(1, 0, 0, 0, 0); put(2, 0, 0, 0, 0); put(3, 0, 1, 0, 0);
        run_seq(1, 1, 4, 0, "R3 legal 00V");
        // R4: legal B0V right after reset
        put(0, 0, 1, 0, 0); put(1, 0, 0, 0, 0); put(2, 0, 1, 0, 0); put(3, 1, 0, 1, 0);
        run_seq(1, 1, 4, 0, "R4 legal B0V");
        // R8: same B0V in dual format, rails cleared
        run_seq(1, 0, 4, 0, "R8 dual B0V");
        // R5: V with even pulse count is an error
        put(0, 0, 0, 0, 0); put(1, 0, 0, 0, 0); put(2, 1, 0, 1, 1); put(3, 0, 0, 0, 0);
        run_seq(1, 1, 4, 0, "R5 even parity V");

        // Random clean streams
        encode(0, 300); run_seq(0, 1, 300, 0,  "R1 ami random");
        encode(1, 300); run_seq(1, 1, 300, 20, "R3 R4 b3zs random gaps");
        encode(1, 300); run_seq(1, 0, 300, 0,  "R8 b3zs dual random");
        encode(1, 300); run_seq(1, 1, 300, 0,  "R9 b3zs single random");
        // Random with injected errors
        encode(1, 300); inject(300); model(1, 300); run_seq(1, 1, 300, 10, "R5 R6 b3zs errors");
        encode(0, 300); inject(300); model(0, 300); run_seq(0, 0, 300, 0,  "R2 R8 ami errors dual");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule